// File: doc/BRIEF.md
# Tick-Driven Real-Time-Clock Interrupt Emulator

This block rebuilds the three classic real-time-clock interrupt sources from a fast, free-running base tick and a time of day supplied from elsewhere. The three sources are the once-per-second update, the hour/minute/second alarm and a periodic interrupt at a power-of-two rate. Each cycle, `tick_inc_i` reports how many base ticks have elapsed. Normally this is 0 or 1. When ticks arrive in bunches from a slower sampling domain, it can be much larger. The block keeps its own tick count. It arms a single compare point and polls the interrupt conditions each time the count reaches that point.

The poll rate is 64 polls per second. When the periodic source is enabled with a faster rate, the poll rate rises to match it. The next compare point is always derived from the previous compare point, not from the current count, so the schedule does not drift. If the count has already run beyond the new point, the skipped intervals are counted. The compare point jumps past the count, and the skipped intervals are credited to the periodic divider.

All sources that are satisfied on the same poll are reported together in one single-cycle `irq_o` pulse. The flag word on `flags_o` says which sources fired.

Top module: `rtc_irq_emu`

## Requirements
- R1: During and after reset, `irq_o` is 0 and `flags_o` is 0 until the first poll that satisfies a source.
- R2: With TICK_LOG2=16, a poll occurs every 2^(16 - P) base ticks. P is 6 (64 polls/s), or the periodic rate exponent when the periodic source is enabled and that exponent exceeds 6. Each poll is a point at which the tick count has reached or passed the current compare point.
- R3: `rate_sel_i` selects a periodic rate of 2^rate_sel_i per second. Values below 1 behave as 1, and values above 13 behave as 13, giving 2 Hz to 8192 Hz.
- R4: With `upd_en_i` set, a poll fires the update source when `sec_i` differs from the seconds value recorded at the previous update. That recorded value is 0 after reset and is refreshed only when the update fires.
- R5: With `per_en_i` set, each poll adds one, plus any skipped intervals, to a periodic count. The periodic source fires when this count reaches 2^(P - rate exponent), and the count then restarts from 0.
- R6: After a poll, the compare point advances by one interval. If the tick count is at or beyond the new point, it advances by a further floor((count - point) / interval) + 1 intervals. That same number is added to the periodic count. A single burst of ticks therefore yields one poll, not a run of back-to-back polls.
- R7: With no source enabled, no poll happens and `irq_o` stays 0. Enabling any source arms the compare point one interval beyond the current count and clears the periodic count. The first poll follows after that interval.
- R8: `flags_o` is nonzero only during an `irq_o` pulse. It then has bits 15:8 = 1, bit 7 = 1 (interrupt flag), bit 6 = periodic, bit 5 = alarm, bit 4 = update, and bits 3:0 = 0.
- R9: When several sources fire on the same poll, a single `irq_o` pulse is produced with all of their flag bits set.
- R10: The alarm time is loaded by `alm_ld_i`. With `alm_en_i` set, a poll fires the alarm source when hours, minutes and seconds all equal the loaded alarm time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_inc_i | input | IW (16) | Base ticks elapsed this cycle |
| hrs_i | input | 5 | Current hours |
| min_i | input | 6 | Current minutes |
| sec_i | input | 6 | Current seconds |
| upd_en_i | input | 1 | Update source enable |
| alm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| rate_sel_i | input | 4 | Periodic rate exponent |
| alm_ld_i | input | 1 | Load strobe for the alarm time |
| alm_hrs_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flags_o | output | 16 | Flag word, valid with `irq_o` |

## Verification
A wrong compare point or interval shows up directly as a change in pulse spacing: polls arrive early, late or in bursts. This is visible at the next poll, within one interval, which is 8 to 1024 base ticks. A corrupted periodic count or recorded second moves or removes the next periodic or update flag, so the divider error is exposed within one full periodic period. Counting pulses over windows that are exact multiples of the period, and timing the first pulse after arming, pins these errors down to the cycle. A cycle-level reference model is also run against random bursts, enables and times.

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu #(
  parameter int TICK_LOG2 = 16,
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13,
  parameter int CW        = 32,
  parameter int IW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] tick_inc_i,
  input  logic [4:0]    hrs_i,
  input  logic [5:0]    min_i,
  input  logic [5:0]    sec_i,
  input  logic          upd_en_i,
  input  logic          alm_en_i,
  input  logic          per_en_i,
  input  logic [3:0]    rate_sel_i,
  input  logic          alm_ld_i,
  input  logic [4:0]    alm_hrs_i,
  input  logic [5:0]    alm_min_i,
  input  logic [5:0]    alm_sec_i,
  output logic          irq_o,
  output logic [15:0]   flags_o
);
  localparam int LW = $clog2(TICK_LOG2 + 1);

  logic [CW-1:0] cnt, cmp, pcnt;
  logic          armed;
  logic [5:0]    prev_sec;
  logic [16:0]   alarm;
  logic [LW-1:0] sel_c, poll_l2, ivl_l2;

  always_comb begin
    if (rate_sel_i < 4'(MIN_LOG2))      sel_c = LW'(MIN_LOG2);
    else if (rate_sel_i > 4'(MAX_LOG2)) sel_c = LW'(MAX_LOG2);
    else                                sel_c = LW'(rate_sel_i);
    poll_l2 = (per_en_i && sel_c > LW'(BASE_LOG2)) ? sel_c : LW'(BASE_LOG2);
    ivl_l2  = LW'(TICK_LOG2) - poll_l2;
  end

  wire          any_en  = upd_en_i | alm_en_i | per_en_i;
  wire [CW-1:0] ivl     = CW'(1) << ivl_l2;
  wire [CW-1:0] due_gap = cnt - cmp;
  wire          due     = armed & any_en & ~due_gap[CW-1];
  wire [CW-1:0] cmp1    = cmp + ivl;
  wire [CW-1:0] gap     = cnt - cmp1;
  wire [CW-1:0] lost    = gap[CW-1] ? '0 : (gap >> ivl_l2) + CW'(1);
  wire [CW-1:0] cmp_nx  = cmp1 + (lost << ivl_l2);
  wire [CW-1:0] pcnt_nx = pcnt + CW'(1) + lost;
  wire [CW-1:0] pdiv    = CW'(1) << (poll_l2 - sel_c);

  wire fire_p = per_en_i & (pcnt_nx >= pdiv);
  wire fire_u = upd_en_i & (sec_i != prev_sec);
  wire fire_a = alm_en_i & ({hrs_i, min_i, sec_i} == alarm);
  wire fire   = due & (fire_p | fire_u | fire_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmp      <= '0;
      pcnt     <= '0;
      armed    <= 1'b0;
      prev_sec <= '0;
      alarm    <= '0;
      irq_o    <= 1'b0;
      flags_o  <= '0;
    end else begin
      cnt     <= cnt + CW'(tick_inc_i);
      irq_o   <= fire;
      flags_o <= fire ? {8'd1, 1'b1, fire_p, fire_a, fire_u, 4'b0000} : 16'h0000;
      if (alm_ld_i) alarm <= {alm_hrs_i, alm_min_i, alm_sec_i};
      if (!any_en) begin
        armed <= 1'b0;
      end else if (!armed) begin
        armed <= 1'b1;
        cmp   <= cnt + ivl;
        pcnt  <= '0;
      end else if (due) begin
        cmp  <= cmp_nx;
        pcnt <= (!per_en_i || fire_p) ? '0 : pcnt_nx;
        if (fire_u) prev_sec <= sec_i;
      end
    end
  end
endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_en_i,
  input logic        alm_en_i,
  input logic        per_en_i,
  input logic        irq_o,
  input logic [15:0] flags_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> flags_o == 16'h0000); // R8
  AST_FLAG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o[15:7] == 9'h003 && flags_o[3:0] == 4'h0)); // R8
  AST_ANY_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |flags_o[6:4]); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_en_i | alm_en_i | per_en_i) |=> !irq_o); // R7
  AST_PF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[6]) |-> $past(per_en_i)); // R5
  AST_UF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[4]) |-> $past(upd_en_i)); // R4
  AST_AF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[5]) |-> $past(alm_en_i)); // R10
endmodule

bind rtc_irq_emu rtc_irq_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en_i(upd_en_i), .alm_en_i(alm_en_i),
  .per_en_i(per_en_i), .irq_o(irq_o), .flags_o(flags_o)
);

// File: tb/test_rtc_irq_emu.sv
`timescale 1ns/1ps
module test_rtc_irq_emu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] tick_inc_i = '0;
  logic [4:0] hrs_i = '0, alm_hrs_i = '0;
  logic [5:0] min_i = '0, sec_i = '0, alm_min_i = '0, alm_sec_i = '0;
  logic upd_en_i = 0, alm_en_i = 0, per_en_i = 0, alm_ld_i = 0;
  logic [3:0] rate_sel_i = '0;
  logic irq_o;
  logic [15:0] flags_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_irq_emu i_rtc_irq_emu (.*);

  // reference model, evaluated from the requirements
  logic [31:0] m_cnt, m_cmp, m_pc, m_ivl, m_c1, m_lost;
  logic m_arm, e_irq, pf, uf, af;
  logic [5:0] m_prev;
  logic [16:0] m_alarm;
  logic [15:0] e_fl;
  int sel, poll;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_pc = 0; m_arm = 0; m_prev = 0; m_alarm = 0;
      e_irq = 0; e_fl = 0;
    end else begin
      sel  = (rate_sel_i < 1) ? 1 : (rate_sel_i > 13) ? 13 : int'(rate_sel_i);
      poll = (per_en_i && sel > 6) ? sel : 6;
      m_ivl = 32'd1 << (16 - poll);
      e_irq = 0; e_fl = 0;
      if (!(upd_en_i | alm_en_i | per_en_i)) m_arm = 0;
      else if (!m_arm) begin m_arm = 1; m_cmp = m_cnt + m_ivl; m_pc = 0; end
      else if ($signed(m_cnt - m_cmp) >= 0) begin
        m_c1 = m_cmp + m_ivl;
        m_lost = ($signed(m_cnt - m_c1) >= 0) ? (m_cnt - m_c1) / m_ivl + 1 : 0;
        m_cmp = m_c1 + m_lost * m_ivl;
        pf = 0;
        if (per_en_i) begin
          m_pc = m_pc + 1 + m_lost;
          if (m_pc >= (32'd1 << (poll - sel))) begin pf = 1; m_pc = 0; end
        end else m_pc = 0;
        uf = upd_en_i && (sec_i != m_prev);
        af = alm_en_i && ({hrs_i, min_i, sec_i} == m_alarm);
        if (uf) m_prev = sec_i;
        if (pf | uf | af) begin e_irq = 1; e_fl = {8'd1, 1'b1, pf, af, uf, 4'b0}; end
      end
      if (alm_ld_i) m_alarm = {alm_hrs_i, alm_min_i, alm_sec_i};
      m_cnt = m_cnt + 32'(tick_inc_i);
    end
  end

  always @(negedge clk) begin
    if (rst_n && (irq_o || e_irq)) begin
      checks++;
      if (irq_o !== e_irq || flags_o !== e_fl) begin
        errors++;
        $display("FAIL R6/R9 model irq=%0b flags=%0h expected irq=%0b flags=%0h",
                 irq_o, flags_o, e_irq, e_fl);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic win(input int n, input logic [15:0] mask, output int k, output logic [15:0] lastf);
    k = 0; lastf = '0;
    repeat (n) begin
      @(negedge clk);
      if (irq_o && (flags_o & mask) != 0) begin k++; lastf = flags_o; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input logic u, input logic a, input logic p);
    upd_en_i = u; alm_en_i = a; per_en_i = p;
  endtask

  task automatic load_alarm(input logic [4:0] h, input logic [5:0] m, input logic [5:0] s);
    alm_hrs_i = h; alm_min_i = m; alm_sec_i = s; alm_ld_i = 1;
    @(negedge clk);
    alm_ld_i = 0;
  endtask

  initial begin
    int k, wait_n;
    logic [15:0] lf;
    void'($urandom(32'h5eed));
    idle(4);
    chk("R1 irq in reset", irq_o, 0);
    chk("R1 flags in reset", flags_o, 0);
    rst_n = 1;
    tick_inc_i = 16;
    idle(3);
    chk("R1 irq after reset", irq_o, 0);

    // R4: seconds equal to post-reset record: no update
    set_en(1, 0, 0);
    win(640, 16'h0010, k, lf);
    chk("R4 no change no update", k, 0);
    sec_i = 5;
    win(640, 16'h0010, k, lf);
    chk("R4 one update on change", k, 1);
    chk("R8 update flags", lf, 16'h0190);
    sec_i = 6;
    win(640, 16'h0010, k, lf);
    chk("R4 next change", k, 1);

    // R10 alarm
    set_en(0, 0, 0);
    load_alarm(1, 2, 3);
    hrs_i = 1; min_i = 2; sec_i = 3;
    set_en(0, 1, 0);
    idle(100);
    win(640, 16'h0020, k, lf);
    chk("R10 alarm match every poll", k, 10);
    chk("R8 alarm flags", lf, 16'h01A0);
    sec_i = 4;
    idle(70);
    win(640, 16'hFFFF, k, lf);
    chk("R10 alarm mismatch silent", k, 0);

    // R9 merge: update and alarm on one poll
    sec_i = 2;
    set_en(1, 1, 0);
    idle(200);
    sec_i = 3;
    k = 0; lf = 0;
    for (int i = 0; i < 100 && k == 0; i++) begin
      @(negedge clk);
      if (irq_o) begin k = 1; lf = flags_o; end
    end
    chk("R9 merged flags", lf, 16'h01B0);

    // R7 disable then re-arm timing
    set_en(0, 0, 0);
    win(300, 16'hFFFF, k, lf);
    chk("R7 disabled silent", k, 0);
    rate_sel_i = 6;
    set_en(0, 0, 1);
    wait_n = 0; k = 0;
    for (int i = 0; i < 200 && k == 0; i++) begin
      @(negedge clk); wait_n++;
      if (irq_o) k = 1;
    end
    chk("R7 first poll after arming", wait_n, 65);

    // R2/R5 64 Hz, divisor 1
    idle(100);
    win(512, 16'h0040, k, lf);
    chk("R2 64Hz polls", k, 8);
    chk("R8 periodic flags", lf, 16'h01C0);

    // R3 8192 Hz and clamped select
    tick_inc_i = 1;
    rate_sel_i = 13;
    idle(1100);
    win(800, 16'h0040, k, lf);
    chk("R3 8192Hz", k, 100);
    rate_sel_i = 15;
    idle(40);
    win(800, 16'h0040, k, lf);
    chk("R3 clamp high", k, 100);

    // R5 divided periodic with clamp low (2 Hz)
    tick_inc_i = 16;
    rate_sel_i = 0;
    idle(2200);
    win(4096, 16'h0040, k, lf);
    chk("R5 R3 2Hz divided", k, 2);

    // R6 burst catch-up
    set_en(0, 0, 0);
    idle(3);
    tick_inc_i = 0;
    rate_sel_i = 1;
    set_en(0, 0, 1);
    idle(3);
    tick_inc_i = 16'd32768;
    @(negedge clk);
    tick_inc_i = 0;
    win(5, 16'h0040, k, lf);
    chk("R6 burst credits periodic", k, 1);
    win(300, 16'hFFFF, k, lf);
    chk("R6 single poll per burst", k, 0);

    // random phase against the model
    for (int s = 0; s < 40; s++) begin
      set_en(1'($urandom), 1'($urandom), 1'($urandom));
      rate_sel_i = 4'($urandom);
      if ($urandom % 3 == 0) load_alarm(hrs_i, min_i, sec_i);
      for (int c = 0; c < 500; c++) begin
        tick_inc_i = ($urandom % 64 == 0) ? 16'(2000 + $urandom % 6000) : 16'($urandom % 40);
        if ($urandom % 150 == 0) sec_i = 6'($urandom % 60);
        @(negedge clk);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule